// File: doc/BRIEF.md
# Comparator-Assisted Successive-Approximation Controller

This block holds the control and status bytes that firmware uses to turn an external 8-bit reference DAC and one analog comparator into a software-driven successive-approximation converter with four selectable inputs. Firmware sets an input-select field and an 8-bit reference code, then sets a start bit. The block samples the synchronized comparator once, keeps the result in a status bit and clears the start bit. Eight such trials, deciding one bit each from the top down, yield an 8-bit conversion.

A second mode serves as a wake-up source. While the threshold-watch bit is set, the block drives a level-sensitive interrupt request for as long as the selected input sits below the reference. When the watch bit is cleared, the request drops at once and the block returns to start-triggered operation. The comparator output enters through a synchronizer. A settle counter keeps any sample from being taken before a changed reference or input select has reached the end of that synchronizer.

Top module: `sadc_assist`

## Requirements
- R1: After reset, both registers read 0x00, and `chan_sel`, `dac_code` and `wake_irq` are 0.
- R2: A write to address 0 loads bits [1:0] into `chan_sel` and bits [7:4] into `dac_code[7:4]`. A write to address 1 loads bits [3:0] into `dac_code[3:0]` and bit 7 into the threshold-watch enable. Both outputs change only on such writes.
- R3: Writing 1 to bit 2 of address 0 sets the start bit. If no settle is pending, the result is latched on the first clock edge after the start bit is set, and the start bit reads 0 from then on.
- R4: A write that changes the reference code or the input select loads a settle count of SYNC_STAGES cycles. A pending start bit is held until the count reaches zero, and only then is the comparator sampled.
- R5: The result bit (address 0, bit 3) is 1 when the synchronized comparator is high, meaning the input is at or above the reference. It holds its value until the next compare completes, and writes to it are ignored.
- R6: `cmp_in` passes through SYNC_STAGES flip-flops before it is sampled or reaches the interrupt. With the default of 2, a change of `cmp_in` reaches `wake_irq` on the third rising edge.
- R7: While the watch enable (address 1, bit 7) is 1, `wake_irq` is high whenever the synchronized comparator is low and low whenever it is high.
- R8: `wake_irq` is low whenever the watch enable is 0, including the cycle right after the write that clears it.
- R9: An 8-step successive approximation run through the registers returns a code equal to the input level of the selected channel.
- R10: `rd_data` is registered and shows the addressed register one cycle after `rd_addr` is applied. Address 1 reads {enable, 000, dac_code[3:0]}, and address 0 reads {dac_code[7:4], result, start, chan_sel}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 control, 1 auxiliary) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Registered read data |
| chan_sel | output | 2 | Analog input select to the mux |
| dac_code | output | 8 | Reference code to the DAC |
| cmp_in | input | 1 | Comparator output, asynchronous |
| wake_irq | output | 1 | Level-sensitive threshold interrupt request |

## Verification
On every cycle the assertions check that the request is never high with the watch bit clear and that it follows the synchronized comparator level. They also check that the start bit clears only when a sample is allowed, that it is held during a settle, that the result changes only on a completion, and that the DAC and select outputs move only on writes. The bench scenarios show what no single-cycle property can: the exact edge on which the result appears, both with and without a settle, the synchronizer delay to the interrupt, and whether the result holds after the input moves. They also show whether full 8-step conversions, swept across every level on one channel and a set of levels on the others, return the right codes.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int DATA_W   = 8;
  localparam int CHAN_W   = 2;
  localparam int NIB_W    = 4;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_AUX  = 1'b1;
  // control byte bit positions
  localparam int CTRL_START_BIT = 2;
  localparam int CTRL_RES_BIT   = 3;
  // auxiliary byte bit positions
  localparam int AUX_WATCH_BIT  = 7;

  typedef struct packed {
    logic              watch;
    logic [DATA_W-1:0] dac;
    logic [CHAN_W-1:0] chan;
  } sadc_cfg_t;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sadc_regs.sv
module sadc_regs
  import sadc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int SETTLE_W = $clog2(SYNC_STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              done,
  output sadc_cfg_t         cfg_q,
  output logic              watch_nxt,
  output logic              start_q,
  output logic              settle_idle
);
  logic          ctrl_we, aux_we;
  sadc_cfg_t     cfg_d;
  logic          cfg_chg;
  logic [SETTLE_W-1:0] settle_q;
  logic          unused_bits;

  assign ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
  assign aux_we  = wr_en && (wr_addr == ADDR_AUX);
  assign unused_bits = ^{wr_data[6:4], wr_data[CTRL_RES_BIT]};

  always_comb begin
    cfg_d = cfg_q;
    if (ctrl_we) begin
      cfg_d.chan                   = wr_data[CHAN_W-1:0];
      cfg_d.dac[DATA_W-1:NIB_W]    = wr_data[DATA_W-1:NIB_W];
    end
    if (aux_we) begin
      cfg_d.dac[NIB_W-1:0]         = wr_data[NIB_W-1:0];
      cfg_d.watch                  = wr_data[AUX_WATCH_BIT];
    end
  end

  assign cfg_chg   = (cfg_d.chan != cfg_q.chan) || (cfg_d.dac != cfg_q.dac);
  assign watch_nxt = cfg_d.watch;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end

  always_ff @(posedge clk) begin
    if (rst)                 settle_q <= '0;
    else if (cfg_chg)        settle_q <= SETTLE_W'(SYNC_STAGES);
    else if (settle_q != '0) settle_q <= settle_q - 1'b1;
  end

  assign settle_idle = (settle_q == '0);

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= (start_q & ~done) | (ctrl_we & wr_data[CTRL_START_BIT]);
  end
endmodule

// File: rtl/sadc_core.sv
module sadc_core (
  input  logic clk,
  input  logic rst,
  input  logic start_q,
  input  logic settle_idle,
  input  logic cmp_s,
  input  logic watch_nxt,
  output logic done,
  output logic res_q,
  output logic irq_q
);
  assign done = start_q & settle_idle;

  always_ff @(posedge clk) begin
    if (rst)       res_q <= 1'b0;
    else if (done) res_q <= cmp_s;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= watch_nxt & ~cmp_s;
  end
endmodule

// File: rtl/sadc_assist.sv
module sadc_assist
  import sadc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_addr,
  output logic [7:0]        rd_data,
  output logic [1:0]        chan_sel,
  output logic [7:0]        dac_code,
  input  logic              cmp_in,
  output logic              wake_irq
);
  sadc_cfg_t cfg_q;
  logic watch_nxt, start_q, settle_idle, done, res_q, cmp_s, irq_q, dc_en;

  sadc_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .cfg_q(cfg_q), .watch_nxt(watch_nxt), .start_q(start_q),
    .settle_idle(settle_idle)
  );

  sadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(cmp_in), .dout(cmp_s)
  );

  sadc_core u_core (
    .clk(clk), .rst(rst), .start_q(start_q), .settle_idle(settle_idle),
    .cmp_s(cmp_s), .watch_nxt(watch_nxt), .done(done), .res_q(res_q),
    .irq_q(irq_q)
  );

  assign chan_sel = cfg_q.chan;
  assign dac_code = cfg_q.dac;
  assign dc_en    = cfg_q.watch;
  assign wake_irq = irq_q;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_addr == ADDR_CTRL)
      rd_data <= {cfg_q.dac[DATA_W-1:NIB_W], res_q, start_q, cfg_q.chan};
    else
      rd_data <= {cfg_q.watch, 3'b000, cfg_q.dac[NIB_W-1:0]};
  end
endmodule

// File: rtl/sadc_assist_chk.sv
module sadc_assist_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [7:0] wr_data,
  input logic [1:0] chan_sel,
  input logic [7:0] dac_code,
  input logic       wake_irq,
  input logic       start_q,
  input logic       settle_idle,
  input logic       res_q,
  input logic       dc_en,
  input logic       cmp_s
);
  assert_irq_off_R8: assert property (@(posedge clk) disable iff (rst)
    !dc_en |-> !wake_irq);

  assert_irq_follows_low_R7: assert property (@(posedge clk) disable iff (rst)
    (dc_en && $past(!cmp_s)) |-> wake_irq);

  assert_irq_needs_low_R7: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> $past(!cmp_s));

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (start_q && settle_idle && !(wr_en && !wr_addr && wr_data[2])) |=> !start_q);

  assert_settle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (start_q && !settle_idle) |=> start_q);

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_q) |-> $past(start_q && settle_idle));

  assert_cfg_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(dac_code) && $stable(chan_sel)));
endmodule

bind sadc_assist sadc_assist_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .chan_sel(chan_sel), .dac_code(dac_code), .wake_irq(wake_irq),
  .start_q(start_q), .settle_idle(settle_idle), .res_q(res_q), .dc_en(dc_en),
  .cmp_s(cmp_s)
);

// File: tb/sim_sadc_assist.sv
module sim_sadc_assist;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] chan_sel;
  logic [7:0] dac_code;
  logic       cmp_in;
  logic       wake_irq;
  logic [7:0] ain [0:3];

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign cmp_in = (ain[chan_sel] >= dac_code);

  sadc_assist u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .chan_sel(chan_sel),
    .dac_code(dac_code), .cmp_in(cmp_in), .wake_irq(wake_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
    rd_addr = 1'b0;
  endtask

  task automatic convert(input logic [1:0] ch, output logic [7:0] code);
    logic [7:0] trial;
    code = '0;
    for (int b = 7; b >= 0; b--) begin
      trial = code | (8'd1 << b);
      wr(1'b1, {4'b0000, trial[3:0]});
      wr(1'b0, {trial[7:4], 1'b0, 1'b1, ch});
      repeat (2) @(negedge clk);
      while (rd_data[2]) @(negedge clk);
      if (rd_data[3]) code = trial;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R9 actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] code;
    for (int i = 0; i < 4; i++) ain[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, d); check(d == 8'h00, "R1 ctrl", d, 0);
    rd(1'b1, d); check(d == 8'h00, "R1 aux", d, 0);
    check(dac_code == 0 && chan_sel == 0 && !wake_irq, "R1 outputs",
          {dac_code, chan_sel, wake_irq}, 0);

    // R2 / R10 field placement and readback
    wr(1'b0, 8'hA2);
    wr(1'b1, 8'h05);
    check(dac_code == 8'hA5, "R2 dac_code", dac_code, 8'hA5);
    check(chan_sel == 2'd2, "R2 chan_sel", chan_sel, 2);
    rd(1'b1, d); check(d == 8'h05, "R10 aux read", d, 8'h05);
    repeat (4) @(negedge clk);
    rd(1'b0, d); check(d[7:4] == 4'hA && d[1:0] == 2'd2, "R10 ctrl read", d, 8'hA2);

    // R3 exact latency with settle idle; R5 result high
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h00);
    ain[0] = 8'd200;
    repeat (5) @(negedge clk);
    rd_addr = 1'b0;
    wr(1'b0, 8'h84);                                   // same dac/chan, start
    @(negedge clk); check(rd_data[2] == 1'b1, "R3 start visible", rd_data[2], 1);
    @(negedge clk); check(rd_data[2] == 1'b0, "R3 start cleared", rd_data[2], 0);
    check(rd_data[3] == 1'b1, "R5 result high", rd_data[3], 1);

    // R5 result low, then held while input moves; write to result bit ignored
    ain[0] = 8'd100;
    repeat (4) @(negedge clk);
    wr(1'b0, 8'h84);
    repeat (2) @(negedge clk);
    check(rd_data[3] == 1'b0, "R5 result low", rd_data[3], 0);
    ain[0] = 8'd250;
    repeat (6) @(negedge clk);
    wr(1'b0, 8'h88);                                   // set result bit, no start
    repeat (2) @(negedge clk);
    check(rd_data[3] == 1'b0, "R5 result held", rd_data[3], 0);

    // R4 settle: start together with a code change
    ain[0] = 8'd150;
    wr(1'b0, 8'h94);                                   // dac 0x90, start
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); check(rd_data[2] == 1'b1, "R4 start held in settle", rd_data[2], 1);
    @(negedge clk); check(rd_data[2] == 1'b0, "R4 start done after settle", rd_data[2], 0);
    check(rd_data[3] == 1'b1, "R4 result after settle", rd_data[3], 1);

    // R7 / R6 / R8 threshold watch
    wr(1'b0, 8'h61);                                   // chan 1, dac 0x64
    wr(1'b1, 8'h04);
    ain[1] = 8'd50;
    repeat (5) @(negedge clk);
    check(!wake_irq, "R8 low while watch off", wake_irq, 0);
    ain[1] = 8'd150;
    repeat (4) @(negedge clk);
    wr(1'b1, 8'h84);                                   // watch on
    repeat (2) @(negedge clk);
    check(!wake_irq, "R7 input above", wake_irq, 0);
    ain[1] = 8'd50;
    @(negedge clk);
    @(negedge clk); check(!wake_irq, "R6 sync delay", wake_irq, 0);
    @(negedge clk); check(wake_irq, "R6 irq on third edge", wake_irq, 1);
    check(wake_irq, "R7 input below", wake_irq, 1);
    ain[1] = 8'd100;                                   // equal counts as not below
    repeat (4) @(negedge clk);
    check(!wake_irq, "R7 input equal", wake_irq, 0);
    ain[1] = 8'd10;
    repeat (4) @(negedge clk);
    check(wake_irq, "R7 input low again", wake_irq, 1);
    wr(1'b1, 8'h04);                                   // watch off
    check(!wake_irq, "R8 cleared immediately", wake_irq, 0);
    rd(1'b1, d); check(d == 8'h04, "R10 aux watch off", d, 8'h04);

    // R9 conversions: exhaustive on channel 0, corners on the others
    for (int v = 0; v < 256; v++) begin
      ain[0] = v[7:0];
      convert(2'd0, code);
      check(code == v[7:0], "R9 sweep ch0", code, v);
    end
    ain[1] = 8'd0; ain[2] = 8'd255; ain[3] = 8'd127;
    for (int c = 1; c < 4; c++) begin
      convert(c[1:0], code);
      check(code == ain[c], "R9 channel", code, ain[c]);
      check(chan_sel == c[1:0], "R2 channel select", chan_sel, c);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule